// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It runs two direction predictors side by side. The local predictor follows each branch's own recent outcomes. The global predictor follows the outcomes of all recently resolved branches. A small table of 2-bit saturating chooser counters, one per branch entry, decides which of the two supplies the final guess.

A fetch stage presents a branch address and reads back the final guess in the same cycle. It also reads back the guess each component made, and it keeps those two bits with the branch. When the branch resolves, the execute stage returns the address, the real outcome and the two kept bits. The predictor then trains both direction tables and the chooser, and it shifts the outcome into the global history.

All tables are untagged and are indexed by the low address bits. Any branches that share those bits also share entries.

Top module: `tbp_top`

## Requirements
- R1: `pred_taken` equals `pred_global` when the chooser counter at the predicted entry has its MSB set (value 2 or 3). Otherwise it equals `pred_local`.
- R2: `pred_local` is the MSB of the local counter table entry selected by the local history stored for the predicted entry.
- R3: `pred_global` is the MSB of the global counter table entry at index (address low `IDX_W` bits) XOR (global history, zero-extended or truncated to `IDX_W`).
- R4: On an update, the chooser counter of the entry moves only when `upd_local_pred` and `upd_global_pred` differ. It increments, saturating at 3, when the global guess matched `upd_taken`. It decrements, saturating at 0, when the local guess matched. As a result, the preferred component changes only after it has been wrong twice in a row from a strong state.
- R5: Every table is untagged. Two addresses that agree in their low `IDX_W` bits read and train the same entries.
- R6: On an update, the local counter entry selected by the entry's current local history is stepped once. So is the global counter entry at (upd address low bits) XOR (the global history before the shift). A step adds one for taken and subtracts one for not-taken, saturating at 0 and 3.
- R7: On an update, the outcome is shifted into bit 0 of the global history and into bit 0 of the local history of the updated entry. The oldest bit is dropped.
- R8: After a synchronous active-low reset, every direction counter holds 01 and every chooser counter holds 01. All histories are zero, so every prediction output reads 0.
- R9: When a prediction and an update hit the same entry in one cycle, the prediction reflects the table contents from before that update.
- R10: While `upd_valid` is low, the update inputs have no effect on any table or history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pred_pc | input | PC_W | Address of the branch being predicted |
| pred_taken | output | 1 | Final taken guess |
| pred_local | output | 1 | Guess from the local predictor |
| pred_global | output | 1 | Guess from the global predictor |
| upd_valid | input | 1 | A resolved branch is presented |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome |
| upd_local_pred | input | 1 | Local guess kept from predict time |
| upd_global_pred | input | 1 | Global guess kept from predict time |

## Verification
A prediction and a training update can fall in the same clock cycle, and they can land on the same table entry. The bench runs branches in a pipelined way: each cycle presents a new address for prediction while the previous branch is being trained. Repeated addresses, aliased addresses and a deliberate predict-on-the-entry-being-trained sequence force this overlap. In each of these cycles, the outputs are sampled before the clock edge and compared against a bench model whose state has not yet absorbed that update. This is how R9 is judged.

// File: rtl/tbp_pkg.sv
// Package: shared counter type and saturating-step helper for the tournament predictor.
// Assumes every counter in the block is 2 bits wide.
package tbp_pkg;
    typedef logic [1:0] ctr2_t;

    localparam ctr2_t CTR_WEAK_LO = 2'b01;

    // Move a 2-bit counter one step up or down, clamping at 0 and 3.
    function automatic ctr2_t ctr_step(input ctr2_t c, input logic up);
        if (up)
            return (c == 2'b11) ? c : c + 2'b01;
        else
            return (c == 2'b00) ? c : c - 2'b01;
    endfunction
endpackage

// File: rtl/tbp_local.sv
// Local predictor: a per-entry history table feeds the index of a table of 2-bit counters.
// Assumes the caller has already reduced the branch address to IDX_W index bits.
module tbp_local
    import tbp_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int LH_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] pred_idx,
    output logic             pred_dir,
    input  logic             upd_valid,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_taken
);
    localparam int ENT   = 1 << IDX_W;
    localparam int P_ENT = 1 << LH_W;

    logic [LH_W-1:0] hist_q [ENT];
    ctr2_t           pht_q  [P_ENT];
    logic [LH_W-1:0] upd_hist;

    // Read path: history of the predicted entry picks a counter; its MSB is the guess.
    assign pred_dir = pht_q[hist_q[pred_idx]][1];
    assign upd_hist = hist_q[upd_idx];

    // Train the counter the history selects, then shift the outcome into that history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENT; i++)   hist_q[i] <= '0;
            for (int j = 0; j < P_ENT; j++) pht_q[j]  <= CTR_WEAK_LO;
        end else if (upd_valid) begin
            pht_q[upd_hist]  <= ctr_step(pht_q[upd_hist], upd_taken);
            hist_q[upd_idx]  <= (upd_hist << 1) | LH_W'(upd_taken);
        end
    end
endmodule

// File: rtl/tbp_global.sv
// Global predictor: a global history shift register is XORed into the index of a counter table.
// Assumes training uses the history as it stands at update time (no speculative repair).
module tbp_global
    import tbp_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int GH_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] pred_idx,
    output logic             pred_dir,
    input  logic             upd_valid,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_taken,
    output logic [GH_W-1:0]  ghr
);
    localparam int ENT = 1 << IDX_W;

    logic [GH_W-1:0]  ghr_q;
    ctr2_t            pht_q [ENT];
    logic [IDX_W-1:0] hfold;
    logic [IDX_W-1:0] p_hash;
    logic [IDX_W-1:0] u_hash;

    assign hfold    = IDX_W'(ghr_q);
    assign p_hash   = pred_idx ^ hfold;
    assign u_hash   = upd_idx ^ hfold;
    assign pred_dir = pht_q[p_hash][1];
    assign ghr      = ghr_q;

    // Train the hashed counter and shift the outcome into the history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ghr_q <= '0;
            for (int i = 0; i < ENT; i++) pht_q[i] <= CTR_WEAK_LO;
        end else if (upd_valid) begin
            pht_q[u_hash] <= ctr_step(pht_q[u_hash], upd_taken);
            ghr_q         <= (ghr_q << 1) | GH_W'(upd_taken);
        end
    end
endmodule

// File: rtl/tbp_chooser.sv
// Chooser: per-entry 2-bit counters; MSB set means trust the global predictor.
// Assumes the component guesses returned at update are the ones issued at predict time.
module tbp_chooser
    import tbp_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] pred_idx,
    output logic             use_global,
    input  logic             upd_valid,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_taken,
    input  logic             upd_local_pred,
    input  logic             upd_global_pred,
    output ctr2_t            upd_ctr
);
    localparam int ENT = 1 << IDX_W;

    ctr2_t sel_q [ENT];
    logic  split;

    assign use_global = sel_q[pred_idx][1];
    assign upd_ctr    = sel_q[upd_idx];
    assign split      = upd_local_pred ^ upd_global_pred;

    // Move toward whichever component was the only one right; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENT; i++) sel_q[i] <= CTR_WEAK_LO;
        end else if (upd_valid && split) begin
            sel_q[upd_idx] <= ctr_step(sel_q[upd_idx], upd_global_pred == upd_taken);
        end
    end
endmodule

// File: rtl/tbp_top.sv
// Tournament direction predictor top: same-cycle prediction and a one-cycle training update.
// Assumes PC_W >= IDX_W; the low IDX_W address bits index every table without tags.
module tbp_top
    import tbp_pkg::*;
#(
    parameter int PC_W  = 8,
    parameter int IDX_W = 4,
    parameter int LH_W  = 3,
    parameter int GH_W  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] pred_pc,
    output logic            pred_taken,
    output logic            pred_local,
    output logic            pred_global,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic            upd_local_pred,
    input  logic            upd_global_pred
);
    logic [IDX_W-1:0] p_idx;
    logic [IDX_W-1:0] u_idx;
    logic             use_global;
    logic [GH_W-1:0]  ghr_w;
    ctr2_t            cho_upd_w;

    assign p_idx = pred_pc[IDX_W-1:0];
    assign u_idx = upd_pc[IDX_W-1:0];

    tbp_local #(.IDX_W(IDX_W), .LH_W(LH_W)) u_local (
        .clk(clk), .rst_n(rst_n), .pred_idx(p_idx), .pred_dir(pred_local),
        .upd_valid(upd_valid), .upd_idx(u_idx), .upd_taken(upd_taken)
    );

    tbp_global #(.IDX_W(IDX_W), .GH_W(GH_W)) u_global (
        .clk(clk), .rst_n(rst_n), .pred_idx(p_idx), .pred_dir(pred_global),
        .upd_valid(upd_valid), .upd_idx(u_idx), .upd_taken(upd_taken), .ghr(ghr_w)
    );

    tbp_chooser #(.IDX_W(IDX_W)) u_chooser (
        .clk(clk), .rst_n(rst_n), .pred_idx(p_idx), .use_global(use_global),
        .upd_valid(upd_valid), .upd_idx(u_idx), .upd_taken(upd_taken),
        .upd_local_pred(upd_local_pred), .upd_global_pred(upd_global_pred),
        .upd_ctr(cho_upd_w)
    );

    // Final guess: the chooser picks one component's direction bit.
    assign pred_taken = use_global ? pred_global : pred_local;
endmodule

// File: rtl/tbp_checker.sv
// Checker: temporal properties of the history register and chooser training, bound to tbp_top.
module tbp_checker #(
    parameter int IDX_W = 4,
    parameter int GH_W  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pred_taken,
    input logic             pred_local,
    input logic             pred_global,
    input logic             upd_valid,
    input logic [IDX_W-1:0] u_idx,
    input logic             upd_taken,
    input logic             upd_local_pred,
    input logic             upd_global_pred,
    input logic [GH_W-1:0]  ghr_w,
    input logic [1:0]       cho_upd_w
);
    AST_PRED_FROM_COMPONENT: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_taken == pred_local) || (pred_taken == pred_global)); // R1

    AST_GHR_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> ghr_w == GH_W'({$past(ghr_w), $past(upd_taken)})); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(ghr_w)); // R10

    AST_CHO_HOLD_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && $past(upd_valid) && u_idx == $past(u_idx)
         && $past(upd_local_pred) == $past(upd_global_pred))
        |-> cho_upd_w == $past(cho_upd_w)); // R4

    AST_CHO_STEP_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && $past(upd_valid) && u_idx == $past(u_idx)
         && $past(upd_local_pred) != $past(upd_global_pred)
         && $past(upd_global_pred) == $past(upd_taken) && $past(cho_upd_w) != 2'b11)
        |-> cho_upd_w == $past(cho_upd_w) + 2'b01); // R4
endmodule

bind tbp_top tbp_checker #(.IDX_W(IDX_W), .GH_W(GH_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pred_taken(pred_taken), .pred_local(pred_local),
    .pred_global(pred_global), .upd_valid(upd_valid), .u_idx(u_idx),
    .upd_taken(upd_taken), .upd_local_pred(upd_local_pred),
    .upd_global_pred(upd_global_pred), .ghr_w(ghr_w), .cho_upd_w(cho_upd_w)
);

// File: tb/tb_tbp_top.sv
// Bench: arithmetic reference model of the tournament predictor, pipelined and directed sweeps.
module tb_tbp_top;
    localparam int PC_W = 8, IDX_W = 4, LH_W = 3, GH_W = 4;
    localparam int ENT = 1 << IDX_W, P_ENT = 1 << LH_W;

    logic clk = 0, rst_n = 0;
    logic [PC_W-1:0] pred_pc = '0, upd_pc = '0;
    logic upd_valid = 0, upd_taken = 0, upd_local_pred = 0, upd_global_pred = 0;
    logic pred_taken, pred_local, pred_global;

    tbp_top #(.PC_W(PC_W), .IDX_W(IDX_W), .LH_W(LH_W), .GH_W(GH_W)) dut (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
        .pred_local(pred_local), .pred_global(pred_global), .upd_valid(upd_valid),
        .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_local_pred(upd_local_pred),
        .upd_global_pred(upd_global_pred)
    );

    always #10 clk = ~clk; // 50 MHz

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // Reference state
    int m_lh [ENT];
    int m_lp [P_ENT];
    int m_gp [ENT];
    int m_ch [ENT];
    int m_ghr;

    // pending branch for pipelined training
    bit pend_v = 0;
    logic [PC_W-1:0] pend_pc;
    bit pend_t, pend_l, pend_g;
    logic [15:0] lfsr = 16'hACE1;

    function automatic int sat(int c, bit up);
        if (up) return (c < 3) ? c + 1 : c;
        return (c > 0) ? c - 1 : c;
    endfunction

    function automatic bit exp_local(int pc);
        return m_lp[m_lh[pc % ENT]] >= 2;
    endfunction
    function automatic bit exp_global(int pc);
        return m_gp[(pc % ENT) ^ m_ghr] >= 2;
    endfunction
    function automatic bit exp_final(int pc);
        return (m_ch[pc % ENT] >= 2) ? exp_global(pc) : exp_local(pc);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < ENT; i++) begin m_lh[i] = 0; m_gp[i] = 1; m_ch[i] = 1; end
        for (int i = 0; i < P_ENT; i++) m_lp[i] = 1;
        m_ghr = 0;
    endtask

    task automatic model_update(int pc, bit t, bit lp, bit gp);
        int ix = pc % ENT;
        int h = m_lh[ix];
        m_lp[h] = sat(m_lp[h], t);
        m_gp[ix ^ m_ghr] = sat(m_gp[ix ^ m_ghr], t);
        if (lp != gp) m_ch[ix] = sat(m_ch[ix], gp == t);
        m_lh[ix] = ((h << 1) | t) % P_ENT;
        m_ghr = ((m_ghr << 1) | t) % (1 << GH_W);
    endtask

    task automatic chk(string tag, string what, bit got, bit exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0b expected %0b (pc %0h)", tag, what, got, exp, pred_pc);
        end
    endtask

    // One cycle: drive, check outputs before the edge against pre-update model, clock, update model.
    task automatic cyc(string tag, logic [PC_W-1:0] ppc, bit v, logic [PC_W-1:0] upc,
                       bit t, bit lp, bit gp, output bit o_l, output bit o_g);
        pred_pc = ppc; upd_valid = v; upd_pc = upc;
        upd_taken = t; upd_local_pred = lp; upd_global_pred = gp;
        #2;
        chk(tag, "R1 pred_taken", pred_taken, exp_final(ppc));
        chk(tag, "R2 pred_local", pred_local, exp_local(ppc));
        chk(tag, "R3 pred_global", pred_global, exp_global(ppc));
        o_l = pred_local; o_g = pred_global;
        @(posedge clk);
        if (v) model_update(upc, t, lp, gp);
        @(negedge clk);
    endtask

    // Pipelined branch: predict this one while the previous one trains.
    task automatic branch(string tag, logic [PC_W-1:0] pc, bit t);
        bit l, g;
        cyc(tag, pc, pend_v, pend_pc, pend_t, pend_l, pend_g, l, g);
        pend_v = 1; pend_pc = pc; pend_t = t; pend_l = l; pend_g = g;
    endtask

    task automatic drain(string tag);
        bit l, g;
        cyc(tag, pend_pc, pend_v, pend_pc, pend_t, pend_l, pend_g, l, g);
        pend_v = 0;
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        bit l, g;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R8: every entry predicts not-taken after reset
        for (int pc = 0; pc < ENT; pc++) cyc("R8", PC_W'(pc), 0, '0, 0, 0, 0, l, g);

        // R10: update inputs toggling with upd_valid low change nothing
        for (int pc = 0; pc < ENT; pc++) cyc("R10", PC_W'(pc), 0, PC_W'(pc), 1, 0, 1, l, g);
        for (int pc = 0; pc < ENT; pc++) cyc("R10", PC_W'(pc), 0, '0, 0, 0, 0, l, g);

        // R4/R9: chooser on entry 5, predicting entry 5 while it trains
        cyc("R4", 8'h05, 1, 8'h05, 1, 0, 1, l, g); // global only right: 1->2
        cyc("R4", 8'h05, 1, 8'h05, 1, 0, 1, l, g); // 2->3
        cyc("R4", 8'h05, 1, 8'h05, 1, 0, 1, l, g); // saturate at 3
        cyc("R4", 8'h05, 1, 8'h05, 0, 0, 0, l, g); // both right: hold
        cyc("R4", 8'h05, 1, 8'h05, 1, 0, 0, l, g); // both wrong: hold
        cyc("R4", 8'h05, 1, 8'h05, 1, 1, 0, l, g); // local only right: 3->2, still global
        cyc("R9", 8'h05, 1, 8'h05, 1, 1, 0, l, g); // 2->1, switches after second miss
        cyc("R4", 8'h05, 1, 8'h05, 0, 0, 1, l, g); // 1->0
        cyc("R4", 8'h05, 1, 8'h05, 0, 0, 1, l, g); // floor at 0
        cyc("R4", 8'h05, 0, '0, 0, 0, 0, l, g);

        // R6/R7: loop-like pattern on one branch, 3 taken then exit
        for (int k = 0; k < 24; k++) branch("R6", 8'h02, (k % 4) != 3);
        drain("R7");

        // R5: aliases sharing low bits train and read the same entries
        for (int k = 0; k < 12; k++) begin
            branch("R5", 8'h13, 1);
            branch("R5", 8'h03, 1);
            branch("R5", 8'hA3, k[0]);
        end
        drain("R5");

        // Near-exhaustive pipelined sweep over all addresses with pseudo-random outcomes
        for (int rep = 0; rep < 4; rep++)
            for (int pc = 0; pc < (1 << PC_W); pc++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                branch((rep == 0) ? "R1" : "R9", PC_W'(pc % 48), lfsr[0] | pc[2]);
            end
        drain("R1");

        // Synchronous reset mid-run brings all back to the initial state
        rst_n = 0;
        @(posedge clk); @(negedge clk);
        rst_n = 1;
        model_reset();
        for (int pc = 0; pc < ENT; pc++) cyc("R8", PC_W'(pc), 0, '0, 0, 0, 0, l, g);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule